// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit sits between a UART datapath and the interrupt controller. Fourteen event lines from neighbouring blocks set bits in a sticky status register. The events are FIFO level conditions, line errors, a modem-line change, a receive timeout, the end of a break, and a bus error. An event may arrive as a single-cycle pulse or as a level that stays high while its condition lasts. A bit set by a level event is set again on every cycle that the level stays high.

An enable register selects which status bits drive one active-high level interrupt line. Two further lines report the same masked status for the receive-related bits and the transmit-related bits, so that a handler can tell which side needs service. Software reaches both registers through a small register-bus port. A read has no side effect. A status bit is acknowledged by writing 1 to that bit.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the enable register and the status register read 0, and `irq`, `rx_irq` and `tx_irq` are low.
- R2: When `src_evt[i]` is high at a clock edge, status bit i is 1 after that edge and stays 1 after the event drops, until software clears it.
- R3: A write to the status register (word address 1) clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: If an event and a write-1 clear of the same bit occur in the same cycle, the bit stays set. A source held high therefore keeps its bit set through repeated clears.
- R5: `irq` is high exactly when some status bit and the enable bit in the same position are both 1. With the enable register at zero, `irq` is low.
- R6: The enable register at word address 0 stores write-data bits 13..0 and reads them back. Bits 31..14 read as 0.
- R7: A write to the status register never sets a bit, and status bits 31..14 always read as 0.
- R8: `rx_irq` is the OR of the enabled status bits 4, 5, 7, 8, 9 and 11. `tx_irq` is the OR of the enabled status bits 2, 3 and 6.
- R9: Word addresses other than 0 and 1 read as 0, and writes to them change no register.
- R10: Bit positions are fixed and shared by the events, status and enable: 0 transmit holding empty, 1 receive holding full, 2 transmit FIFO nearly empty, 3 transmit FIFO empty, 4 receive FIFO nearly full, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity error, 9 framing error, 10 CTS change, 11 receive timeout, 12 break finished, 13 bus error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 14 | Event lines, one for each status bit |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read is selected |
| irq | output | 1 | Level interrupt request |
| rx_irq | output | 1 | Pending enabled receive-side events |
| tx_irq | output | 1 | Pending enabled transmit-side events |

## Verification
The assertions check on every cycle the following rules. An event always leaves its bit set on the next cycle. A bit never sets without an event. A bit that was not written with 1 never clears. A bit written with 1 and carrying no event clears. The group lines never rise without `irq`, and `irq` stays low while nothing is enabled. The bench scenarios are the only check of the bit map itself and of the group membership of each bit. They also cover the masking of each bit by its enable, the 14-bit readback width, the inert unmapped addresses, and the collision of a clear with a held level event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 14;

  // event bit positions
  localparam int B_TX_HOLD_EMPTY = 0;
  localparam int B_RX_HOLD_FULL  = 1;
  localparam int B_TXF_LOW       = 2;
  localparam int B_TXF_EMPTY     = 3;
  localparam int B_RXF_HIGH      = 4;
  localparam int B_RXF_FULL      = 5;
  localparam int B_TX_UNDERRUN   = 6;
  localparam int B_RX_OVERRUN    = 7;
  localparam int B_PARITY        = 8;
  localparam int B_FRAMING       = 9;
  localparam int B_CTS_CHANGE    = 10;
  localparam int B_RX_TIMEOUT    = 11;
  localparam int B_BREAK_END     = 12;
  localparam int B_BUS_ERR       = 13;

  localparam logic [NSRC-1:0] RX_GROUP =
      NSRC'((1 << B_RXF_HIGH) | (1 << B_RXF_FULL) | (1 << B_RX_OVERRUN) |
            (1 << B_PARITY) | (1 << B_FRAMING) | (1 << B_RX_TIMEOUT));
  localparam logic [NSRC-1:0] TX_GROUP =
      NSRC'((1 << B_TXF_LOW) | (1 << B_TXF_EMPTY) | (1 << B_TX_UNDERRUN));

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int N         = 14,
  parameter int EN_ADDR   = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N-1:0]      en_q,
  input  logic [N-1:0]      stat_q,
  output logic              en_we,
  output logic [N-1:0]      en_wdata,
  output logic [N-1:0]      clr_vec,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - N;

  reg_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (bus_sel) begin
      if (bus_addr == ADDR_W'(EN_ADDR))        sel = SEL_EN;
      else if (bus_addr == ADDR_W'(STAT_ADDR)) sel = SEL_STAT;
    end
  end

  always_comb begin
    en_we    = bus_wr && (sel == SEL_EN);
    en_wdata = bus_wdata[N-1:0];
    clr_vec  = (bus_wr && (sel == SEL_STAT)) ? bus_wdata[N-1:0] : '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      case (sel)
        SEL_EN:   bus_rdata = {{PAD_W{1'b0}}, en_q};
        SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, stat_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_enable.sv
module uart_irq_enable #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] en_q
);
  logic [N-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (en_we) en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] stat_q
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic bit_d;
    logic bit_ce;

    always_comb begin
      bit_ce = evt[b] | clr_vec[b];
      bit_d  = evt[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat_q[b] <= 1'b0;
      else if (bit_ce) stat_q[b] <= bit_d;
    end
  end
endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine #(
  parameter int           N       = 14,
  parameter logic [N-1:0] RX_MASK = '0,
  parameter logic [N-1:0] TX_MASK = '0
) (
  input  logic [N-1:0] stat_q,
  input  logic [N-1:0] en_q,
  output logic         irq,
  output logic         rx_irq,
  output logic         tx_irq
);
  logic [N-1:0] live;

  always_comb begin
    live   = stat_q & en_q;
    irq    = |live;
    rx_irq = |(live & RX_MASK);
    tx_irq = |(live & TX_MASK);
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int EN_ADDR   = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_evt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic            rst_int_n;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] stat_q;
  logic            en_we;
  logic [NSRC-1:0] en_wdata;
  logic [NSRC-1:0] clr_vec;

  uart_irq_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  uart_irq_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(NSRC),
    .EN_ADDR(EN_ADDR), .STAT_ADDR(STAT_ADDR)
  ) regif_i (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_q(en_q), .stat_q(stat_q),
    .en_we(en_we), .en_wdata(en_wdata), .clr_vec(clr_vec),
    .bus_rdata(bus_rdata)
  );

  uart_irq_enable #(.N(NSRC)) enable_i (
    .clk(clk), .rst_n(rst_int_n), .en_we(en_we),
    .en_wdata(en_wdata), .en_q(en_q)
  );

  uart_irq_status #(.N(NSRC)) status_i (
    .clk(clk), .rst_n(rst_int_n), .evt(src_evt),
    .clr_vec(clr_vec), .stat_q(stat_q)
  );

  uart_irq_combine #(.N(NSRC), .RX_MASK(RX_GROUP), .TX_MASK(TX_GROUP)) comb_i (
    .stat_q(stat_q), .en_q(en_q), .irq(irq), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );
endmodule

// File: rtl/uart_irq_unit_chk.sv
module uart_irq_unit_chk #(
  parameter int N         = 14,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int STAT_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      src_evt,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              rx_irq,
  input logic              tx_irq,
  input logic [N-1:0]      stat_q,
  input logic [N-1:0]      en_q
);
  logic [N-1:0] clr_req;
  assign clr_req = (bus_sel && bus_wr && bus_addr == ADDR_W'(STAT_ADDR))
                   ? bus_wdata[N-1:0] : '0;

  // R2: an event leaves its bit set on the next cycle
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(src_evt)) == $past(src_evt)));

  // R7: no bit sets without an event
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(src_evt)) == '0));

  // R3: a bit not written with 1 keeps its value when set
  a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~$past(clr_req) & ~stat_q) == '0));

  // R3 / R4: a write-1 clears only where no event collides
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_req) & ~$past(src_evt)) == '0));

  // R8: group lines never rise without the main line
  a_r8_group_implies_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq || tx_irq) |-> irq);

  // R5: nothing enabled means no request
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R6 / R7: upper read bits are zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:N] == '0);
endmodule

bind uart_irq_unit uart_irq_unit_chk #(
  .N(uart_irq_pkg::NSRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_int_n), .src_evt(src_evt), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .rx_irq(rx_irq), .tx_irq(tx_irq),
  .stat_q(stat_q), .en_q(en_q)
);

// File: tb/uart_irq_unit_tb_top.sv
module uart_irq_unit_tb_top;
  localparam int N = 14;
  localparam logic [31:0] RXM = 32'h0000_0BB0; // bits 4,5,7,8,9,11
  localparam logic [31:0] TXM = 32'h0000_004C; // bits 2,3,6
  localparam logic [31:0] ALL = 32'h0000_3FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_evt = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  uart_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1ns d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk);
    src_evt = v;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8ns * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] one;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, r); chk("R1 enable", r, 0);
    rd(4'd1, r); chk("R1 status", r, 0);
    chk("R1 irq", {29'd0, irq, rx_irq, tx_irq}, 0);

    // R6 enable width
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, r); chk("R6 enable readback", r, ALL);
    wr(4'd0, 32'h0000_2A55); rd(4'd0, r); chk("R6 enable pattern", r, 32'h2A55);
    wr(4'd0, 32'd0); rd(4'd0, r); chk("R6 enable zero", r, 0);

    // R7 writing ones to an empty status sets nothing
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, r); chk("R7 no set by write", r, 0);

    // Sweep each source position
    for (int i = 0; i < N; i++) begin
      one = 32'd1 << i;
      pulse(one[N-1:0]);
      rd(4'd1, r); chk($sformatf("R2 R10 sticky bit %0d", i), r, one);
      chk($sformatf("R5 disabled bit %0d", i), {31'd0, irq}, 0);
      wr(4'd0, one);
      chk($sformatf("R5 enabled bit %0d", i), {31'd0, irq}, 1);
      chk($sformatf("R8 rx bit %0d", i), {31'd0, rx_irq}, {31'd0, |(RXM & one)});
      chk($sformatf("R8 tx bit %0d", i), {31'd0, tx_irq}, {31'd0, |(TXM & one)});
      wr(4'd0, ALL & ~one);
      chk($sformatf("R5 other enables bit %0d", i), {29'd0, irq, rx_irq, tx_irq}, 0);
      wr(4'd1, 32'd0); rd(4'd1, r); chk($sformatf("R3 write0 bit %0d", i), r, one);
      wr(4'd1, ALL & ~one); rd(4'd1, r); chk($sformatf("R3 other ones bit %0d", i), r, one);
      wr(4'd1, one); rd(4'd1, r); chk($sformatf("R3 clear bit %0d", i), r, 0);
      chk($sformatf("R5 after clear bit %0d", i), {31'd0, irq}, 0);
      wr(4'd0, 32'd0);
    end

    // R2 several at once, partial clear
    pulse(14'h2491);
    rd(4'd1, r); chk("R2 multi set", r, 32'h2491);
    wr(4'd1, 32'h0480); rd(4'd1, r); chk("R3 partial clear", r, 32'h2011);
    wr(4'd1, ALL); rd(4'd1, r); chk("R3 clear all", r, 0);

    // R4 collision and held level
    @(negedge clk);
    src_evt = 14'h0020;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h20;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    rd(4'd1, r); chk("R4 set wins over clear", r, 32'h20);
    wr(4'd1, 32'h20); rd(4'd1, r); chk("R4 level re-asserts", r, 32'h20);
    src_evt = '0;
    wr(4'd1, 32'h20); rd(4'd1, r); chk("R4 clears after level drops", r, 0);

    // R9 unmapped addresses
    wr(4'd0, 32'h0000_1234);
    pulse(14'h0101);
    for (int a = 2; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rd(a[3:0], r); chk($sformatf("R9 read addr %0d", a), r, 0);
    end
    rd(4'd0, r); chk("R9 enable untouched", r, 32'h1234);
    rd(4'd1, r); chk("R9 status untouched", r, 32'h0101);
    chk("R8 rx with bit 8", {31'd0, rx_irq}, 0);
    wr(4'd0, 32'h0000_0100);
    chk("R8 rx parity", {30'd0, rx_irq, tx_irq}, 32'h2);

    done = 1'b1;
    finish_run();
  end
endmodule